// File: doc/BRIEF.md
# Second-Order Digital Sigma-Delta Modulator

This block turns a stream of 16-bit signed transmit words into a single-bit stream. The rest of the chip gives it a word at twice the base sample rate, with a load strobe, and a tick enable at the oversampling rate, which is 128 times the base rate. Each held word therefore spans 64 output bits. On every tick the modulator runs two cascaded accumulators with error feedback. The sign of the second accumulator picks the next output bit. The feedback is plus full scale when the current bit is 1 and minus full scale when it is 0.

The accumulators carry guard bits above the sample width and saturate instead of wrapping, which keeps the loop stable when the input is at full scale. When the enable input is low, the loop rests. The accumulators and the held word clear, and on every tick the output toggles, giving the 1/0 pattern that stands for zero. The output feeds an external analog reconstruction stage.

Top module: `sdm2_tx`

## Requirements
- R1: Asynchronous reset (rst_n low) clears the held word and both accumulators and sets bit_out to 0.
- R2: bit_out changes only on a clock edge where tick is 1. Without tick, all loop state holds.
- R3: The held word takes the value of din at a clock edge where load and en are both 1. At any other edge where en is 1, the held word keeps its value.
- R4: At a tick edge with en at 1, the feedback value f is +32768 if bit_out is 1 and -32768 if it is 0. The updates are a1' = sat(a1 + x - f) and a2' = sat(a2 + a1' - f), where x is the held word. bit_out becomes 1 exactly when a2' >= 0, and the new value is visible after that edge.
- R5: Both accumulators are 20-bit signed values. The saturation function sat() clamps each result to the range [-524288, 524287] and never wraps.
- R6: At an edge where en is 0, both accumulators and the held word clear and load is ignored. At each tick edge with en at 0, bit_out inverts.
- R7: With a constant input x held over N ticks, the number of 1 bits is within 4 of N*(x+32768)/65536.
- R8: When load and tick arrive at the same edge, that tick uses the word that was held before the edge. The new word is used from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the loop when 1. When 0, clears the loop and selects the idle toggle pattern |
| tick | input | 1 | Oversampling-rate step enable |
| load | input | 1 | Strobe at the double sample rate that captures din |
| din | input | 16 | Signed two's-complement transmit word |
| bit_out | output | 1 | Modulated single-bit stream |

## Verification
The bound checker checks on every cycle these properties:
- bit_out stays still without a tick.
- bit_out inverts on idle ticks, and idle clears the accumulators.
- The held word changes only through a load.
- The new bit follows the sign of the second accumulator.
- The first accumulator never jumps across zero the way a wrap would.

Only the bench's scenarios can show the following:
- The exact bit sequence under the feedback equations, compared against an independent integer model.
- The ones density that a constant input produces.
- The order of a load and a tick that arrive together.
- The behaviour at full-scale input.

// File: rtl/sdm2_pkg.sv
`timescale 1ns/1ps
package sdm2_pkg;
  // loop mode seen by the output stage
  typedef enum logic {
    LOOP_IDLE = 1'b0,
    LOOP_RUN  = 1'b1
  } loop_mode_e;

  localparam int unsigned SDM2_DW_DEFAULT    = 16;
  localparam int unsigned SDM2_GUARD_DEFAULT = 4;

  function automatic loop_mode_e mode_of(input logic enable);
    return enable ? LOOP_RUN : LOOP_IDLE;
  endfunction
endpackage

// File: rtl/sdm2_sample_hold.sv
`timescale 1ns/1ps
module sdm2_sample_hold #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 load,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] held
);
  logic capture;
  assign capture = en & load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (!en) begin
      held <= '0;
    end else if (capture) begin
      held <= din;
    end
  end
endmodule

// File: rtl/sdm2_integrator.sv
`timescale 1ns/1ps
module sdm2_integrator #(
  parameter int unsigned AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic signed [AW-1:0] in_val,
  input  logic signed [AW-1:0] fb_val,
  output logic signed [AW-1:0] acc_q,
  output logic signed [AW-1:0] acc_next
);
  localparam int SW = AW + 2;
  localparam logic signed [SW-1:0] HI = SW'((64'sd1 <<< (AW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  function automatic logic signed [SW-1:0] widen(input logic signed [AW-1:0] v);
    return $signed({{2{v[AW-1]}}, v});
  endfunction

  // acc + in - fb, clamped to the accumulator range
  function automatic logic signed [AW-1:0] sat_step(
    input logic signed [AW-1:0] a,
    input logic signed [AW-1:0] b,
    input logic signed [AW-1:0] c
  );
    logic signed [SW-1:0] s;
    s = widen(a) + widen(b) - widen(c);
    if (s > HI)      return HI[AW-1:0];
    else if (s < LO) return LO[AW-1:0];
    else             return s[AW-1:0];
  endfunction

  assign acc_next = sat_step(acc_q, in_val, fb_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/sdm2_quantizer.sv
`timescale 1ns/1ps
module sdm2_quantizer #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic signed [AW-1:0] last_acc_next,
  output logic                 bit_q,
  output logic signed [AW-1:0] fb_val
);
  import sdm2_pkg::*;

  localparam logic signed [AW-1:0] FS_POS = AW'(64'sd1 <<< (DW - 1));
  localparam logic signed [AW-1:0] FS_NEG = -FS_POS;

  loop_mode_e mode;
  logic       next_bit;

  assign mode   = mode_of(en);
  assign fb_val = bit_q ? FS_POS : FS_NEG;

  always_comb begin
    unique case (mode)
      LOOP_RUN:  next_bit = ~last_acc_next[AW-1];
      default:   next_bit = ~bit_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (tick) begin
      bit_q <= next_bit;
    end
  end
endmodule

// File: rtl/sdm2_tx.sv
`timescale 1ns/1ps
module sdm2_tx #(
  parameter int unsigned DW    = sdm2_pkg::SDM2_DW_DEFAULT,
  parameter int unsigned GUARD = sdm2_pkg::SDM2_GUARD_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          bit_out
);
  localparam int unsigned AW     = DW + GUARD;
  localparam int unsigned NSTAGE = 2;

  logic signed [DW-1:0] held_word;
  logic signed [AW-1:0] x_ext;
  logic signed [AW-1:0] fb_val;
  logic signed [AW-1:0] stage_in   [NSTAGE];
  logic signed [AW-1:0] stage_acc  [NSTAGE];
  logic signed [AW-1:0] stage_next [NSTAGE];
  logic                 loop_step;
  logic                 loop_clear;

  // named events for the checker
  logic signed [AW-1:0] acc1_q;
  logic signed [AW-1:0] acc2_q;
  logic signed [AW-1:0] acc2_next;

  assign loop_step  = en & tick;
  assign loop_clear = ~en;
  assign x_ext      = $signed({{GUARD{held_word[DW-1]}}, held_word});

  sdm2_sample_hold #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .load  (load),
    .din   ($signed(din)),
    .held  (held_word)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSTAGE; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign stage_in[gi] = x_ext;
      end else begin : g_chain
        assign stage_in[gi] = stage_next[gi-1];
      end
      sdm2_integrator #(.AW(AW)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (loop_clear),
        .step     (loop_step),
        .in_val   (stage_in[gi]),
        .fb_val   (fb_val),
        .acc_q    (stage_acc[gi]),
        .acc_next (stage_next[gi])
      );
    end
  endgenerate

  assign acc1_q    = stage_acc[0];
  assign acc2_q    = stage_acc[NSTAGE-1];
  assign acc2_next = stage_next[NSTAGE-1];

  sdm2_quantizer #(.AW(AW), .DW(DW)) u_quant (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .tick          (tick),
    .last_acc_next (acc2_next),
    .bit_q         (bit_out),
    .fb_val        (fb_val)
  );
endmodule

// File: rtl/sdm2_tx_chk.sv
`timescale 1ns/1ps
module sdm2_tx_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 tick,
  input logic                 load,
  input logic [DW-1:0]        din,
  input logic                 bit_out,
  input logic signed [DW-1:0] held_word,
  input logic signed [AW-1:0] acc1_q,
  input logic signed [AW-1:0] acc2_q
);
  localparam logic signed [AW-1:0] NEAR_TOP = AW'(64'sd1 <<< (AW - 2));
  localparam logic signed [AW-1:0] NEAR_BOT = -NEAR_TOP;

  AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bit_out)); // R2

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (held_word == $signed($past(din)))); // R3

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> $stable(held_word)); // R3

  AST_BIT_FOLLOWS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> (bit_out == !acc2_q[AW-1])); // R4

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && acc1_q > NEAR_TOP) |=> (acc1_q > 0)); // R5

  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && acc1_q < NEAR_BOT) |=> (acc1_q < 0)); // R5

  AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && tick) |=> (bit_out != $past(bit_out))); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc1_q == 0 && acc2_q == 0 && held_word == 0)); // R6
endmodule

bind sdm2_tx sdm2_tx_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tick      (tick),
  .load      (load),
  .din       (din),
  .bit_out   (bit_out),
  .held_word (held_word),
  .acc1_q    (acc1_q),
  .acc2_q    (acc2_q)
);

// File: tb/sdm2_tx_test.sv
`timescale 1ns/1ps
module sdm2_tx_test;
  localparam int FS  = 32768;
  localparam int AHI = 524287;
  localparam int ALO = -524288;

  typedef struct {
    logic  exp_bit;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        tick = 1'b0;
  logic        load = 1'b0;
  logic [15:0] din = '0;
  logic        bit_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb[$];

  // bench-side model state
  int  m_a1 = 0;
  int  m_a2 = 0;
  int  m_x  = 0;
  logic m_y = 1'b0;

  always #2.5 clk = ~clk;

  sdm2_tx uut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .load(load), .din(din), .bit_out(bit_out)
  );

  function automatic int clamp(input int v);
    if (v > AHI) return AHI;
    if (v < ALO) return ALO;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one clock cycle of stimulus plus its predicted outcome
  task automatic step(input logic e, input logic t, input logic l,
                      input int d, input string tag);
    item_t it;
    int f, n1, n2;
    @(negedge clk);
    en = e; tick = t; load = l; din = 16'(d);
    if (!e) begin
      m_a1 = 0; m_a2 = 0; m_x = 0;
      if (t) m_y = ~m_y;
    end else begin
      if (t) begin
        f  = m_y ? FS : -FS;
        n1 = clamp(m_a1 + m_x - f);
        n2 = clamp(m_a2 + n1 - f);
        m_a1 = n1; m_a2 = n2;
        m_y = (n2 >= 0);
      end
      if (l) m_x = d;
    end
    it.exp_bit = m_y;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, int'(bit_out), int'(it.exp_bit));
    end
  end

  task automatic run_dc(input int x, input int n, input string tag);
    int ones;
    ones = 0;
    step(1'b1, 1'b0, 1'b1, x, tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, 1'b0, 0, tag);
      @(posedge clk); #1;
      ones += int'(bit_out);
    end
    checks++;
    if ((ones - (n * (x + FS)) / (2 * FS)) > 4 ||
        ((n * (x + FS)) / (2 * FS) - ones) > 4) begin
      fails++;
      $display("FAIL R7 density: actual %0d expected %0d", ones,
               (n * (x + FS)) / (2 * FS));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset output", int'(bit_out), 0);
    rst_n = 1'b1;

    // R6: idle toggling, loads ignored
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 12345, "R6");
    step(1'b0, 1'b0, 1'b1, 777, "R6");
    // enable without a load: held word must be zero (R6/R1 state)
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 0, "R6 zero word");

    // R4: mid-level input, every-cycle ticks
    step(1'b1, 1'b0, 1'b1, 9000, "R4");
    for (int i = 0; i < 128; i++) step(1'b1, 1'b1, 1'b0, 0, "R4");

    // R2: sparse ticks, bit must hold between them
    step(1'b1, 1'b0, 1'b1, -20000, "R2");
    for (int i = 0; i < 90; i++) step(1'b1, (i % 3) == 0, 1'b0, 0, "R2");

    // R8: load together with tick
    step(1'b1, 1'b1, 1'b1, 30000, "R8");
    step(1'b1, 1'b1, 1'b1, -30000, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 0, "R8");

    // R3: ramp reloaded every 64 ticks, strobes only while loading
    for (int w = 0; w < 6; w++) begin
      step(1'b1, 1'b1, 1'b1, -25000 + w * 10000, "R3");
      for (int i = 0; i < 63; i++) step(1'b1, 1'b1, 1'b0, 0, "R3");
    end

    // R5: full-scale inputs
    step(1'b1, 1'b0, 1'b1, 32767, "R5");
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0, 0, "R5");
    step(1'b1, 1'b0, 1'b1, -32768, "R5");
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0, 0, "R5");

    // R7: ones density
    run_dc(16384, 1024, "R7");
    run_dc(-24576, 1024, "R7");

    // R6: disable mid-run then resume
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 0, "R6");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 0, "R6 resume");

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule